// File: doc/BRIEF.md
# Serially Programmed Clock Fan-Out Gate

This block is the digital core of a clock fan-out buffer. It takes one reference clock and makes twelve output pairs and one feedback copy from it. Each pair has a true output and a complement output. A slave on a two-wire SMBus holds the enable bits. The host sends a block write that carries a run of data bytes. Two of those bytes hold one enable bit per output pair and one bit for the feedback output. A pair whose bit is 0 drives both of its outputs low.

Two pins act directly on the outputs. An active-low power-down pin forces every output low, whatever the enable bits hold. A mode pin selects how the complement outputs behave. With the pin at 1, every pair is differential. With the pin at 0, the complement outputs of the six lowest pairs carry plain copies of the reference, as a single-ended memory module needs.

The block works in the domain of a system clock. SCL and SDA pass through synchronisers before they are used. The reference clock is treated as a synchronous input: it is sampled on each system clock edge, and every output is a register. The outputs therefore lag the reference by one system clock. A new set of enables takes effect only while the reference is low, so that no output ever produces a clipped high pulse.

Top module: `clkgate_smbus_ctrl`

## Requirements
- R1: The block acknowledges only the address byte 0xD2, which is the 7-bit address 1101001 followed by a write bit of 0. Any other address byte, including the same address with the read bit set, is not acknowledged. Nothing in that transaction is acknowledged or stored, and the outputs do not change.
- R2: A matching transaction has this form: START, then the address byte, a command byte, a byte count and the data bytes, then STOP. Each byte is sent most significant bit first. The slave acknowledges every byte by asserting `sda_pull_o` while SCL is low before the ninth clock, and releases it after the ninth clock falls.
- R3: Data bytes take positions 0, 1, 2 and upward, in the order they arrive. Bytes past position 7 are discarded, and the byte count value is not used. A short write changes only the positions it reaches.
- R4: The bits of position 7 enable pairs 0 to 7, with bit k driving pair k. Bits 3 to 0 of position 6 enable pairs 11 to 8, with bit j driving pair 8+j. Bit 4 of position 6 enables the feedback output. Bits 7 to 5 of position 6 are reserved and stored as 0. An enable bit of 1 lets the output run.
- R5: After reset, every enable bit is 1 and `sda_pull_o` is 0.
- R6: While `pwr_dn_n_i` is 0, every true, complement and feedback output is 0 one system clock later.
- R7: With `mode_ddr_i` = 1, an enabled pair drives its true output equal to `ref_i` and its complement output equal to NOT `ref_i`, one system clock after `ref_i` is sampled. Pairs 6 to 11 behave this way in both modes.
- R8: With `mode_ddr_i` = 0, the complement outputs of enabled pairs 0 to 5 equal `ref_i`, as their true outputs do.
- R9: A disabled pair drives both of its outputs to 0. A disabled feedback output is also 0.
- R10: A new enable setting is applied only on a system clock edge where `ref_i` is sampled low. While `ref_i` stays high, the outputs keep the previous setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SMBus clock line |
| sda_i | input | 1 | SMBus data line as seen on the wire |
| sda_pull_o | output | 1 | Pull-low enable for the open-drain data line |
| ref_i | input | 1 | Reference clock, sampled by `clk` |
| pwr_dn_n_i | input | 1 | Active-low power-down |
| mode_ddr_i | input | 1 | 1 = all pairs differential; 0 = pairs 0 to 5 single-ended |
| clk_t_o | output | 12 | True output of each pair |
| clk_c_o | output | 12 | Complement output of each pair |
| clk_fb_o | output | 1 | Feedback copy of the reference |

## Verification
The bench writes a single enable bit at a time over all thirteen enable bits, and also writes all zeros and a mixed pattern. After each write it checks every output across both modes, both power-down levels and both reference levels. A swapped bit order, a wrong byte position, or pair 5 and pair 6 treated alike would each show up as a wrong output column. Writes with a foreign address and with the read bit set must leave the outputs unchanged and draw no acknowledge; a loose address compare would do the opposite. A seven-byte write must leave position 7 untouched. A sixteen-byte write must keep positions 6 and 7 from being overwritten by bytes 14 and 15, which a wrapping index would do. In another test the reference is held high through a write that disables everything. The outputs must stay running until the reference has gone low once; a design that applies the write at once would cut the high phase short.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_ADDR,
    RX_CMD,
    RX_COUNT,
    RX_DATA,
    RX_SKIP
  } rx_state_e;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_sh, sda_sh;
  logic              scl_prev, sda_prev;
  logic              scl_s, sda_s;

  assign scl_s = scl_sh[STAGES-1];
  assign sda_s = sda_sh[STAGES-1];

  // Idle bus level is high, so the chains reset to ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh   <= '1;
      sda_sh   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sh   <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh   <= {sda_sh[STAGES-2:0], sda_i};
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign sda_s_o    = sda_s;
  assign scl_rise_o = scl_s & ~scl_prev;
  assign scl_fall_o = ~scl_s & scl_prev;
  // Data edges while the clock stays high frame a transaction.
  assign start_o    = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_o     = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/smb_byte_rx.sv
module smb_byte_rx
  import clkgate_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter int         NBYTES     = 8,
  localparam int        AW         = $clog2(NBYTES),
  localparam int        CW         = $clog2(NBYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  output logic          sda_pull_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_idx_o,
  output logic [7:0]    wr_data_o
);

  localparam logic [CW-1:0] LAST_POS = CW'(NBYTES);

  rx_state_e      state;
  logic [3:0]     bitcnt;
  logic [6:0]     shreg;
  logic           ack_pend;
  logic [CW-1:0]  pos;
  logic [7:0]     rx_byte;

  assign rx_byte = {shreg, sda_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RX_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      ack_pend   <= 1'b0;
      sda_pull_o <= 1'b0;
      pos        <= '0;
      wr_en_o    <= 1'b0;
      wr_idx_o   <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_det) begin
        state      <= RX_ADDR;
        bitcnt     <= '0;
        ack_pend   <= 1'b0;
        sda_pull_o <= 1'b0;
      end else if (stop_det) begin
        state      <= RX_IDLE;
        bitcnt     <= '0;
        ack_pend   <= 1'b0;
        sda_pull_o <= 1'b0;
      end else if (state != RX_IDLE && state != RX_SKIP) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            shreg  <= rx_byte[6:0];
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd7) begin
              ack_pend <= 1'b1;
              case (state)
                RX_ADDR: begin
                  if (rx_byte == {SLAVE_ADDR, 1'b0}) begin
                    state <= RX_CMD;
                  end else begin
                    state    <= RX_SKIP;
                    ack_pend <= 1'b0;
                  end
                end
                RX_CMD:   state <= RX_COUNT;
                RX_COUNT: begin
                  state <= RX_DATA;
                  pos   <= '0;
                end
                RX_DATA: begin
                  if (pos < LAST_POS) begin
                    wr_en_o   <= 1'b1;
                    wr_idx_o  <= pos[AW-1:0];
                    wr_data_o <= rx_byte;
                    pos       <= pos + 1'b1;
                  end
                end
                default: ;
              endcase
            end
          end else if (bitcnt == 4'd8) begin
            bitcnt <= 4'd9;
          end
        end else if (scl_fall) begin
          if (bitcnt == 4'd8 && ack_pend) begin
            sda_pull_o <= 1'b1;
          end else if (bitcnt == 4'd9) begin
            sda_pull_o <= 1'b0;
            bitcnt     <= '0;
            ack_pend   <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/clkgate_en_regs.sv
module clkgate_en_regs #(
  parameter int  NBYTES   = 8,
  parameter int  FB_BYTE  = 6,
  parameter int  LO_BYTE  = 7,
  parameter int  HI_PAIRS = 4,
  localparam int AW       = $clog2(NBYTES),
  localparam int NEN      = 8 + HI_PAIRS + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_idx,
  input  logic [7:0]     wr_data,
  input  logic           ref_i,
  output logic [NEN-1:0] en_act_o
);

  // Only the two positions that reach the outputs are kept; the
  // rest are accepted on the bus and dropped.
  logic [HI_PAIRS:0] fb_byte_q;
  logic [7:0]        lo_byte_q;
  logic [NEN-1:0]    en_shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_byte_q <= '1;
      lo_byte_q <= '1;
    end else if (wr_en) begin
      if (wr_idx == AW'(FB_BYTE)) fb_byte_q <= wr_data[HI_PAIRS:0];
      if (wr_idx == AW'(LO_BYTE)) lo_byte_q <= wr_data;
    end
  end

  assign en_shadow = {fb_byte_q, lo_byte_q};

  // Hand over to the output stage only during the low phase.
  always_ff @(posedge clk) begin
    if (rst)         en_act_o <= '1;
    else if (!ref_i) en_act_o <= en_shadow;
  end

endmodule

// File: rtl/clkgate_out_drv.sv
module clkgate_out_drv #(
  parameter int NPAIRS = 12,
  parameter int NSDR   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_i,
  input  logic              pwr_dn_n_i,
  input  logic              mode_ddr_i,
  input  logic [NPAIRS:0]   en_i,
  output logic [NPAIRS-1:0] clk_t_o,
  output logic [NPAIRS-1:0] clk_c_o,
  output logic              clk_fb_o
);

  for (genvar gp = 0; gp < NPAIRS; gp++) begin : g_pair
    logic c_next;
    if (gp < NSDR) begin : g_dual
      assign c_next = mode_ddr_i ? ~ref_i : ref_i;
    end else begin : g_diff
      assign c_next = ~ref_i;
    end

    always_ff @(posedge clk) begin
      if (rst || !pwr_dn_n_i || !en_i[gp]) begin
        clk_t_o[gp] <= 1'b0;
        clk_c_o[gp] <= 1'b0;
      end else begin
        clk_t_o[gp] <= ref_i;
        clk_c_o[gp] <= c_next;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !pwr_dn_n_i || !en_i[NPAIRS]) clk_fb_o <= 1'b0;
    else                                     clk_fb_o <= ref_i;
  end

endmodule

// File: rtl/clkgate_smbus_ctrl.sv
module clkgate_smbus_ctrl #(
  parameter logic [6:0] SLAVE_ADDR  = 7'h69,
  parameter int         NBYTES      = 8,
  parameter int         FB_BYTE     = 6,
  parameter int         LO_BYTE     = 7,
  parameter int         HI_PAIRS    = 4,
  parameter int         NSDR        = 6,
  parameter int         SYNC_STAGES = 2,
  localparam int        NPAIRS      = 8 + HI_PAIRS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic              ref_i,
  input  logic              pwr_dn_n_i,
  input  logic              mode_ddr_i,
  output logic [NPAIRS-1:0] clk_t_o,
  output logic [NPAIRS-1:0] clk_c_o,
  output logic              clk_fb_o
);

  localparam int AW = $clog2(NBYTES);

  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          wr_en;
  logic [AW-1:0] wr_idx;
  logic [7:0]    wr_data;
  logic [NPAIRS:0] en_act;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  smb_byte_rx #(.SLAVE_ADDR(SLAVE_ADDR), .NBYTES(NBYTES)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sda_pull_o (sda_pull_o),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data)
  );

  clkgate_en_regs #(
    .NBYTES(NBYTES), .FB_BYTE(FB_BYTE), .LO_BYTE(LO_BYTE), .HI_PAIRS(HI_PAIRS)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .ref_i    (ref_i),
    .en_act_o (en_act)
  );

  clkgate_out_drv #(.NPAIRS(NPAIRS), .NSDR(NSDR)) u_drv (
    .clk        (clk),
    .rst        (rst),
    .ref_i      (ref_i),
    .pwr_dn_n_i (pwr_dn_n_i),
    .mode_ddr_i (mode_ddr_i),
    .en_i       (en_act),
    .clk_t_o    (clk_t_o),
    .clk_c_o    (clk_c_o),
    .clk_fb_o   (clk_fb_o)
  );

endmodule

// File: rtl/clkgate_smbus_ctrl_chk.sv
module clkgate_smbus_ctrl_chk #(
  parameter int NPAIRS = 12,
  parameter int NSDR   = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_i,
  input logic              sda_pull_o,
  input logic              ref_i,
  input logic              pwr_dn_n_i,
  input logic              mode_ddr_i,
  input logic [NPAIRS-1:0] clk_t_o,
  input logic [NPAIRS-1:0] clk_c_o,
  input logic              clk_fb_o
);

  // R2: acknowledge is only raised while the bus clock is low
  a_r2_ack_on_low_scl: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |-> !scl_i);

  // R6: power-down clears every output on the next edge
  a_r6_pd_forces_low: assert property (@(posedge clk) disable iff (rst)
    !pwr_dn_n_i |=> (clk_t_o == '0 && clk_c_o == '0 && !clk_fb_o));

  // R7: a high true output always comes from a high reference
  a_r7_true_follows_ref: assert property (@(posedge clk) disable iff (rst)
    (|clk_t_o) |-> $past(ref_i));

  // R7: the upper pairs are never high on both legs
  a_r7_upper_pairs_diff: assert property (@(posedge clk) disable iff (rst)
    (clk_t_o[NPAIRS-1:NSDR] & clk_c_o[NPAIRS-1:NSDR]) == '0);

  // R7: in differential mode no pair is high on both legs
  a_r7_ddr_mode_diff: assert property (@(posedge clk) disable iff (rst)
    mode_ddr_i |=> ((clk_t_o & clk_c_o) == '0));

  // R8: single-ended mode makes the lower complement legs match the true legs
  a_r8_sdram_lower_equal: assert property (@(posedge clk) disable iff (rst)
    !mode_ddr_i |=> (clk_c_o[NSDR-1:0] == clk_t_o[NSDR-1:0]));

  // R9: the feedback output only runs from a high reference
  a_r9_fb_follows_ref: assert property (@(posedge clk) disable iff (rst)
    clk_fb_o |-> $past(ref_i));

endmodule

bind clkgate_smbus_ctrl clkgate_smbus_ctrl_chk #(.NPAIRS(NPAIRS), .NSDR(NSDR)) u_chk (.*);

// File: tb/clkgate_smbus_ctrl_tb.sv
module clkgate_smbus_ctrl_tb;

  localparam int H = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        scl = 1'b1, sda_drv = 1'b1;
  logic        ref_in = 1'b0, pd_n = 1'b1, mode = 1'b1;
  logic        sda_pull;
  logic        sda_line;
  logic [11:0] t_o, c_o;
  logic        fb_o;

  assign sda_line = sda_drv & ~sda_pull;

  clkgate_smbus_ctrl u_dut (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull),
    .ref_i      (ref_in),
    .pwr_dn_n_i (pd_n),
    .mode_ddr_i (mode),
    .clk_t_o    (t_o),
    .clk_c_o    (c_o),
    .clk_fb_o   (fb_o)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [4:0] m_b6 = 5'h1F;
  logic [7:0] m_b7 = 8'hFF;
  logic [7:0] wbuf [16];

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic logic [24:0] exp_out(input bit r, input bit m, input bit p);
    logic [12:0] en;
    logic [11:0] tt, cc;
    en = {m_b6, m_b7};
    for (int i = 0; i < 12; i++) begin
      tt[i] = p & en[i] & r;
      cc[i] = p & en[i] & (((i < 6) && !m) ? r : !r);
    end
    return {p & en[12] & r, cc, tt};
  endfunction

  // Compare all outputs across mode, power-down and reference levels.
  task automatic sweep(input string req);
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 2; p++) begin
        for (int r = 0; r < 2; r++) begin
          logic [24:0] e;
          mode = m[0]; pd_n = p[0]; ref_in = r[0];
          hold(3);
          e = exp_out(r[0], m[0], p[0]);
          check({fb_o, c_o, t_o} == e, req, "outputs", 32'({fb_o, c_o, t_o}), 32'(e));
        end
      end
    end
    ref_in = 1'b0; mode = 1'b1; pd_n = 1'b1;
    hold(3);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; scl = 1'b1; hold(H);
    sda_drv = 1'b0; hold(H);
    scl = 1'b0; hold(H);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; hold(H);
    scl = 1'b1; hold(H);
    sda_drv = 1'b1; hold(H);
  endtask

  task automatic bus_byte(input logic [7:0] b, input bit exp_ack, input string req);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; hold(H);
      scl = 1'b1; hold(H);
      scl = 1'b0; hold(H);
    end
    sda_drv = 1'b1; hold(H);
    check(sda_pull == exp_ack, req, "acknowledge", 32'(sda_pull), 32'(exp_ack));
    scl = 1'b1; hold(H);
    scl = 1'b0; hold(H);
  endtask

  // Block write: address, command, count, then n data bytes from wbuf.
  task automatic write_block(input logic [7:0] addr_byte, input int n);
    bit hit;
    hit = (addr_byte == 8'hD2);
    bus_start();
    bus_byte(addr_byte, hit, "R1");
    bus_byte(8'h00, hit, "R2");
    bus_byte(8'(n), hit, "R2");
    for (int i = 0; i < n; i++) bus_byte(wbuf[i], hit, "R2");
    bus_stop();
    hold(4);
    if (hit) begin
      for (int i = 0; i < n && i < 8; i++) begin
        if (i == 6) m_b6 = wbuf[i][4:0];
        if (i == 7) m_b7 = wbuf[i];
      end
    end
  endtask

  task automatic load_enables(input logic [12:0] en);
    for (int i = 0; i < 16; i++) wbuf[i] = 8'hA5 ^ 8'(i);
    wbuf[6] = {3'b111, en[12:8]};
    wbuf[7] = en[7:0];
  endtask

  initial begin
    hold(5);
    rst = 1'b0;
    hold(4);

    // R5: reset state
    check(sda_pull == 1'b0, "R5", "pull after reset", 32'(sda_pull), 32'h0);
    sweep("R5");

    // R1: foreign address and read bit are ignored
    load_enables(13'h0000);
    write_block(8'hD0, 8);
    sweep("R1");
    write_block(8'hD3, 8);
    sweep("R1");
    write_block(8'h52, 8);
    sweep("R1");

    // R4 R7 R8 R9: one enable bit at a time
    for (int k = 0; k < 13; k++) begin
      load_enables(13'(1) << k);
      write_block(8'hD2, 8);
      sweep("R4");
    end
    load_enables(13'h0000);
    write_block(8'hD2, 8);
    sweep("R9");
    load_enables(13'h1A5C);
    write_block(8'hD2, 8);
    sweep("R8");

    // R3: short write reaches position 6 only
    load_enables(13'h03F0);
    write_block(8'hD2, 7);
    check(m_b7 == 8'h5C, "R3", "model keeps position 7", 32'(m_b7), 32'h5C);
    sweep("R3");

    // R3: bytes beyond position 7 are dropped
    load_enables(13'h1E0F);
    wbuf[14] = 8'h00;
    wbuf[15] = 8'h00;
    write_block(8'hD2, 16);
    sweep("R3");

    // R10: no change while the reference stays high
    load_enables(13'h1FFF);
    write_block(8'hD2, 8);
    ref_in = 1'b1; mode = 1'b1; pd_n = 1'b1;
    hold(3);
    load_enables(13'h0000);
    write_block(8'hD2, 8);
    check(t_o == 12'hFFF, "R10", "true outputs held", 32'(t_o), 32'hFFF);
    check(fb_o == 1'b1, "R10", "feedback held", 32'(fb_o), 32'h1);
    ref_in = 1'b0; hold(3);
    ref_in = 1'b1; hold(3);
    check({fb_o, c_o, t_o} == 25'h0, "R10", "applied after low phase",
          32'({fb_o, c_o, t_o}), 32'h0);
    ref_in = 1'b0; hold(3);
    sweep("R9");

    // R6: power-down with everything enabled
    load_enables(13'h1FFF);
    write_block(8'hD2, 8);
    sweep("R6");

    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
      report();
      $finish;
    end
  end

endmodule